// File: doc/BRIEF.md
# Fast-RAM Overlay Address Mapper

This block sits between an accelerated CPU and a slow host bus. While the overlay is switched on, it steers CPU accesses to the low host RAM into on-board fast RAM, which runs at full speed. Every other address is passed to the host bus. The overlay can cover the whole low RAM area (32 KB) or only its lower half (16 KB). The ROM space above 32 KB always goes to the host.

Software can also turn on a write-through mirror. The mirror covers a window of up to 20 KB at the top of the overlay, which is where the video memory lives. A write inside that window is stored in fast RAM and is also copied to host RAM, so the display stays correct. Only these mirrored writes and real host accesses stall the CPU. The stall starts in the cycle the host access is requested and ends in the cycle the host side acknowledges it. The host bus timing engine and the RAM contents are outside this block.

A control register sets the overlay behaviour. It resets to zero, so the overlay is off until software has filled the fast RAM and switches it on.

Top module: `ovl_mapper`

## Requirements
- R1: After reset the control register is zero and the overlay is off. Every CPU access then goes to the host, and fast_sel stays low.
- R2: With the overlay on and full size, any access below 0x8000 asserts fast_sel in the request cycle. It does not stall the CPU and does not start a host cycle.
- R3: With the half-size bit set, only addresses below 0x4000 are overlaid. Addresses from 0x4000 to 0x7FFF go to the host.
- R4: An address at or above 0x8000 never asserts fast_sel and always starts a host cycle, whatever the control register holds.
- R5: With the mirror on, a write to the mirrored window asserts fast_sel and fast_we and also starts a host write. The window runs from the overlay top minus N KB up to the overlay top, where N is the mirror-size field, and is limited at zero.
- R6: An overlaid read, and an overlaid write outside the mirrored window, complete without stall and without a host cycle.
- R7: cpu_stall is high in the cycle a host access is requested and stays high until host_ack is seen; it is low in the acknowledge cycle. host_req is high from the next cycle through the acknowledge cycle, with host_addr and host_we holding the captured access. Requests made while a host access is in progress are ignored.
- R8: fast_addr equals cpu_addr zero-extended to the fast-RAM width, with no offset.
- R9: A ctl_load pulse writes ctl_wdata into the control register, and the new value applies from the next cycle. The fields are: bit 0 overlay on, bit 1 half size, bit 2 mirror on, bits 7:3 mirror size in KB.
- R10: A mirror-size field above 20 is treated as 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_we | input | 1 | CPU write (1) / read (0) |
| cpu_req | input | 1 | CPU access strobe |
| ctl_load | input | 1 | Load the control register |
| ctl_wdata | input | 8 | Control register value |
| host_ack | input | 1 | Host cycle complete |
| fast_sel | output | 1 | Fast RAM select |
| fast_we | output | 1 | Fast RAM write enable |
| fast_addr | output | FAST_AW | Fast RAM address |
| host_req | output | 1 | Host cycle request |
| host_we | output | 1 | Host cycle direction |
| host_addr | output | ADDR_W | Host cycle address |
| cpu_stall | output | 1 | Hold the CPU |

## Verification
The fast-RAM selects and cpu_stall are combinational. They are due in the same cycle as the request, so the bench samples them two nanoseconds after it drives inputs on the falling edge. host_req, host_addr and host_we come from registers. They are due one edge after the stalled request and must hold until the acknowledge cycle. The bench reference model updates its own busy flag and latched access at each rising edge, so every comparison uses the state the design should have in that cycle. The host acknowledge comes from the bench with a chosen latency, including zero-wait, so the stall's first and last cycles are checked at both extremes.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  typedef struct packed {
    logic [4:0] mir_kb;
    logic       mir_en;
    logic       half;
    logic       en;
  } ovl_ctl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOST = 1'b1
  } host_st_t;

  function automatic logic [5:0] clamp_kb(input logic [4:0] kb, input int unsigned max_kb);
    logic [5:0] r;
    r = (32'(kb) > max_kb) ? 6'(max_kb) : {1'b0, kb};
    return r;
  endfunction

endpackage

// File: rtl/ovl_ctl_reg.sv
module ovl_ctl_reg
  import ovl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] wdata,
  output ovl_ctl_t   ctl
);

  ovl_ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl;
    if (load) ctl_d = ovl_ctl_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else        ctl <= ctl_d;
  end

endmodule

// File: rtl/ovl_decode.sv
module ovl_decode
  import ovl_pkg::*;
#(
  parameter int unsigned PAGE_W        = 6,
  parameter int unsigned OVL_KB        = 32,
  parameter int unsigned MIRROR_MAX_KB = 20
) (
  input  logic [PAGE_W-1:0] page,
  input  logic              we,
  input  ovl_ctl_t          ctl,
  output logic              in_ovl,
  output logic              need_host
);

  localparam int unsigned KW = PAGE_W + 1;

  logic [KW-1:0] top_kb;
  logic [KW-1:0] mir_kb;
  logic [KW-1:0] low_kb;
  logic          mirrored;

  always_comb begin
    top_kb    = ctl.half ? KW'(OVL_KB / 2) : KW'(OVL_KB);
    mir_kb    = KW'(clamp_kb(ctl.mir_kb, MIRROR_MAX_KB));
    low_kb    = (top_kb > mir_kb) ? (top_kb - mir_kb) : '0;
    in_ovl    = ctl.en && ({1'b0, page} < top_kb);
    mirrored  = ctl.mir_en && we && in_ovl && ({1'b0, page} >= low_kb);
    need_host = !in_ovl || mirrored;
  end

endmodule

// File: rtl/ovl_host_fsm.sv
module ovl_host_fsm
  import ovl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              ack,
  output logic              busy,
  output logic              stall_busy,
  output logic [ADDR_W-1:0] h_addr,
  output logic              h_we
);

  host_st_t          st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic              cap_en;

  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_HOST;
        cap_en = 1'b1;
      end
      ST_HOST: if (ack) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      we_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cap_en) begin
        addr_q <= addr;
        we_q   <= we;
      end
    end
  end

  assign busy       = (st_q == ST_HOST);
  assign stall_busy = busy && !ack;
  assign h_addr     = addr_q;
  assign h_we       = we_q;

endmodule

// File: rtl/ovl_mapper.sv
module ovl_mapper
  import ovl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned FAST_AW       = 17,
  parameter int unsigned OVL_KB        = 32,
  parameter int unsigned MIRROR_MAX_KB = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_we,
  input  logic               cpu_req,
  input  logic               ctl_load,
  input  logic [7:0]         ctl_wdata,
  input  logic               host_ack,
  output logic               fast_sel,
  output logic               fast_we,
  output logic [FAST_AW-1:0] fast_addr,
  output logic               host_req,
  output logic               host_we,
  output logic [ADDR_W-1:0]  host_addr,
  output logic               cpu_stall
);

  localparam int unsigned KB_SH  = 10;
  localparam int unsigned PAGE_W = ADDR_W - KB_SH;

  logic     rst_s1, rst_sn;
  ovl_ctl_t ctl;
  logic     in_ovl, need_host, busy, stall_busy, start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  ovl_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_sn), .load(ctl_load), .wdata(ctl_wdata), .ctl(ctl)
  );

  ovl_decode #(.PAGE_W(PAGE_W), .OVL_KB(OVL_KB), .MIRROR_MAX_KB(MIRROR_MAX_KB)) u_dec (
    .page(cpu_addr[ADDR_W-1:KB_SH]), .we(cpu_we), .ctl(ctl),
    .in_ovl(in_ovl), .need_host(need_host)
  );

  assign start = cpu_req && need_host && !busy;

  ovl_host_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_sn), .start(start), .addr(cpu_addr), .we(cpu_we),
    .ack(host_ack), .busy(busy), .stall_busy(stall_busy),
    .h_addr(host_addr), .h_we(host_we)
  );

  assign fast_sel  = cpu_req && in_ovl && !busy;
  assign fast_we   = fast_sel && cpu_we;
  assign host_req  = busy;
  assign cpu_stall = start || stall_busy;

  generate
    if (FAST_AW > ADDR_W) begin : g_zext
      assign fast_addr = {{(FAST_AW - ADDR_W){1'b0}}, cpu_addr};
    end else begin : g_trunc
      assign fast_addr = cpu_addr[FAST_AW-1:0];
    end
  endgenerate

endmodule

// File: rtl/ovl_mapper_chk.sv
module ovl_mapper_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_sn,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_we,
  input logic              cpu_req,
  input logic              host_ack,
  input logic              fast_sel,
  input logic              fast_we,
  input logic              host_req,
  input logic [ADDR_W-1:0] host_addr,
  input logic              cpu_stall,
  input logic              ctl_en
);

  p_stall_until_ack_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (host_req && !host_ack) |-> cpu_stall);

  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (host_req && !host_ack) |=> host_req);

  p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (host_req && host_ack) |=> !host_req);

  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (cpu_req && cpu_stall && !host_req) |=> (host_req && host_addr == $past(cpu_addr)));

  p_rom_host_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (cpu_req && !host_req && cpu_addr[ADDR_W-1]) |-> (cpu_stall && !fast_sel));

  p_off_no_fast_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    !ctl_en |-> !fast_sel);

  p_read_fast_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (fast_sel && !cpu_we) |-> !cpu_stall);

  p_we_gated_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    fast_we |-> fast_sel);

endmodule

bind ovl_mapper ovl_mapper_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
  .cpu_req(cpu_req), .host_ack(host_ack), .fast_sel(fast_sel),
  .fast_we(fast_we), .host_req(host_req), .host_addr(host_addr),
  .cpu_stall(cpu_stall), .ctl_en(ctl.en)
);

// File: tb/test_ovl_mapper.sv
`timescale 1ns/1ps
module test_ovl_mapper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_we = 1'b0, cpu_req = 1'b0, ctl_load = 1'b0, host_ack = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        fast_sel, fast_we, host_req, host_we, cpu_stall;
  logic [16:0] fast_addr;
  logic [15:0] host_addr;

  int n_tests = 0, n_fail = 0;

  // reference model state
  logic [7:0]  m_ctl = '0;
  bit          m_busy = 0;
  int          m_cnt = 0;
  logic [15:0] m_addr = '0;
  logic        m_we = 0;

  always #4 clk = ~clk;

  ovl_mapper i_ovl_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_req(cpu_req), .ctl_load(ctl_load), .ctl_wdata(ctl_wdata),
    .host_ack(host_ack), .fast_sel(fast_sel), .fast_we(fast_we),
    .fast_addr(fast_addr), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .cpu_stall(cpu_stall)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_in_ovl(input logic [15:0] a);
    int top;
    top = m_ctl[1] ? 16384 : 32768;
    return m_ctl[0] && (int'(a) < top);
  endfunction

  function automatic bit m_need_host(input logic [15:0] a, input logic w);
    int top, n, low;
    top = m_ctl[1] ? 16384 : 32768;
    n = int'(m_ctl[7:3]);
    if (n > 20) n = 20;
    low = top - n * 1024;
    if (low < 0) low = 0;
    if (!m_in_ovl(a)) return 1;
    return m_ctl[2] && w && (int'(a) >= low);
  endfunction

  // one clock: drive at falling edge, check, update model at rising edge
  task automatic step(input string tag, input logic [15:0] a, input logic w, input logic rq,
                      input logic ld, input logic [7:0] ld_v, input int lat, output bit stalled);
    bit e_fast, e_stall, ack;
    @(negedge clk);
    ack = m_busy && (m_cnt >= lat);
    cpu_addr = a; cpu_we = w; cpu_req = rq; ctl_load = ld; ctl_wdata = ld_v; host_ack = ack;
    #2;
    if (!m_busy) begin
      e_fast  = rq && m_in_ovl(a);
      e_stall = rq && m_need_host(a, w);
      chk(tag, "fast_sel", fast_sel, e_fast);
      chk(tag, "fast_we", fast_we, e_fast && w);
      chk(tag, "cpu_stall", cpu_stall, e_stall);
      chk("R7", "host_req idle", host_req, 0);
      if (e_fast) chk("R8", "fast_addr", fast_addr, {1'b0, a});
    end else begin
      e_stall = !ack;
      chk("R7", "fast_sel busy", fast_sel, 0);
      chk("R7", "cpu_stall busy", cpu_stall, e_stall);
      chk("R7", "host_req", host_req, 1);
      chk("R7", "host_addr", host_addr, m_addr);
      chk("R7", "host_we", host_we, m_we);
    end
    stalled = e_stall;
    @(posedge clk);
    if (!m_busy) begin
      if (rq && m_need_host(a, w)) begin
        m_busy = 1; m_cnt = 0; m_addr = a; m_we = w;
      end
    end else if (ack) m_busy = 0;
    else m_cnt++;
    if (ld) m_ctl = ld_v;
  endtask

  task automatic access(input string tag, input logic [15:0] a, input logic w, input int lat);
    bit s;
    int guard = 0;
    do begin
      step(tag, a, w, 1'b1, 1'b0, 8'h00, lat, s);
      guard++;
    end while (s && guard < 50);
    step(tag, 16'h0, 1'b0, 1'b0, 1'b0, 8'h00, lat, s);
  endtask

  task automatic set_ctl(input logic [7:0] v);
    bit s;
    step("R9", 16'h0, 1'b0, 1'b0, 1'b1, v, 0, s);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "host_req reset", host_req, 0);
    chk("R1", "cpu_stall reset", cpu_stall, 0);
    access("R1", 16'h1000, 1'b0, 2);
    access("R1", 16'h0000, 1'b1, 0);
    // R9 enable full overlay
    set_ctl(8'h01);
    access("R2", 16'h0000, 1'b0, 0);
    access("R2", 16'h7FFF, 1'b0, 0);
    access("R2", 16'h2000, 1'b1, 0);
    access("R4", 16'h8000, 1'b0, 0);
    access("R4", 16'hC000, 1'b1, 3);
    access("R4", 16'hFFFF, 1'b0, 1);
    // R3 half size
    set_ctl(8'h03);
    access("R3", 16'h3FFF, 1'b0, 0);
    access("R3", 16'h4000, 1'b0, 2);
    access("R3", 16'h7FFF, 1'b1, 0);
    // R5/R6 mirror 20KB, full size: window 0x3000..0x7FFF
    set_ctl(8'hA5);
    access("R5", 16'h3000, 1'b1, 2);
    access("R6", 16'h2FFF, 1'b1, 0);
    access("R6", 16'h3000, 1'b0, 0);
    access("R5", 16'h7FFF, 1'b1, 1);
    access("R4", 16'h9000, 1'b1, 0);
    // R10 mirror size 31 treated as 20
    set_ctl(8'hFD);
    access("R10", 16'h2FFF, 1'b1, 0);
    access("R10", 16'h3000, 1'b1, 0);
    // R5 half size with 4KB mirror: window 0x3000..0x3FFF
    set_ctl(8'h27);
    access("R5", 16'h3000, 1'b1, 4);
    access("R6", 16'h2FFF, 1'b1, 0);
    access("R3", 16'h4000, 1'b1, 0);
    // R9 control load takes effect next cycle; switch off
    set_ctl(8'h00);
    access("R9", 16'h0100, 1'b0, 1);
    // R7 request change while busy is ignored
    step("R7", 16'h8000, 1'b0, 1'b1, 1'b0, 8'h00, 3, s);
    step("R7", 16'h0010, 1'b1, 1'b1, 1'b0, 8'h00, 3, s);
    step("R7", 16'h0010, 1'b1, 1'b1, 1'b0, 8'h00, 3, s);
    step("R7", 16'h0010, 1'b1, 1'b0, 1'b0, 8'h00, 3, s);
    step("R7", 16'h0010, 1'b1, 1'b0, 1'b0, 8'h00, 3, s);
    step("R7", 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 3, s);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule